// File: doc/BRIEF.md
# External Bus Mastership Handshake Controller

This block sits beside a processor's external bus interface and decides who owns the bus. An outside DMA agent asks for the bus by pulling an active-low request line low. When the processor is between bus cycles and its core does not need the bus, the controller lowers an active-low grant output. The grant stays low for a guaranteed minimum number of clocks. After that it returns high when the core asks for the bus again or when the agent withdraws its request. One idle clock always follows before the core may start a new cycle.

While the processor owns the bus, the controller tracks the current cycle: its direction and how many data beats it carries. A retry input can end the cycle early. On a read, retry counts only until the first data beat is accepted. On a write, it counts in every beat. When a cycle is ended by retry, the core receives a one-clock abort pulse so that it can issue the cycle again.

During cold reset the grant pin is not driven. Its level is captured as a configuration mode bit, which keeps its value after reset is released.

Top module: `busm_ctrl`

## Requirements
- R1: While cold reset is low and right after it is released, grant_n is 1, cyc_abort is 0. After release, grant_oe is 1 and bus_free is 1.
- R2: mode_bit5 takes the level on grant_pin_in while cold reset is low. It keeps that level after release, whatever grant_pin_in does later.
- R3: When the bus is idle and core_need is 0, grant_n falls on the third rising edge after ext_req_n goes low. The first two edges are synchronizer stages.
- R4: Once grant_n falls, it stays 0 for at least MIN_LOW (default 2) clocks, even if the reason to release it came earlier.
- R5: After the minimum low time, grant_n returns to 1 on the edge where core_need is seen high.
- R6: After the minimum low time, grant_n returns to 1 on the third rising edge after ext_req_n returns high.
- R7: bus_free is 0 in the clock after grant_n rises, and it is 1 in the clock after that.
- R8: A request that arrives during a processor bus cycle keeps grant_n at 1 until that cycle ends. The grant then falls one clock after the cycle completes.
- R9: A read retry (retry_n low) seen before any data_ack of the cycle ends the cycle. cyc_abort is 1 for exactly one clock, on the third edge after retry_n falls, and bus_free returns to 1 at the same time.
- R10: On a read, retry after the first accepted data beat is ignored: no abort occurs, and the cycle ends normally after its remaining beats.
- R11: On a write, retry ends the cycle with an abort pulse in any beat, including after beats have been accepted.
- R12: A cycle begun with cyc_start while bus_free is 1 makes bus_free 0 on the next clock. bus_free returns to 1 on the edge that accepts the cyc_beats-th data_ack.
- R13: grant_oe is 0 whenever cold reset is low, so the grant pin is treated as an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Active-low cold reset, asynchronous assertion |
| ext_req_n | input | 1 | Active-low bus request from the external agent (asynchronous) |
| core_need | input | 1 | Core needs the bus back |
| retry_n | input | 1 | Active-low retry for the current processor cycle |
| data_ack | input | 1 | One data beat accepted this clock |
| cyc_start | input | 1 | Core starts a bus cycle (taken only while bus_free) |
| cyc_write | input | 1 | Direction of the starting cycle, 1 = write |
| cyc_beats | input | BEAT_W | Beat count of the starting cycle (0 behaves as 1) |
| grant_pin_in | input | 1 | Level read back from the grant pin |
| grant_n | output | 1 | Active-low bus grant |
| grant_oe | output | 1 | Drive enable for the grant pin |
| bus_free | output | 1 | Core may start a cycle this clock |
| cyc_abort | output | 1 | One-clock pulse: current cycle ended by retry |
| mode_bit5 | output | 1 | Configuration bit captured during cold reset |

## Verification
The grant falls three edges after the request: two synchronizer edges and one state edge. It returns on the edge that sees core_need, or three edges after the request is withdrawn. An abort is due three edges after retry_n falls, and a cycle ends on the same edge as its last acknowledge. The bench drives every input on the falling clock edge and samples on the falling edge that follows the rising edge where a result is due. It counts the clocks between stimulus and response, checks that count against these latencies, and checks the exact clock as well. For the handoff table, the expected length of the grant pulse follows from the clock in which each release is applied.

// File: rtl/busm_pkg.sv
package busm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CYC   = 3'd1,
        ST_GMIN  = 3'd2,
        ST_GHOLD = 3'd3,
        ST_RECL  = 3'd4
    } busm_st_e;
endpackage

// File: rtl/busm_sync.sv
module busm_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/busm_beats.sv
module busm_beats #(
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BEAT_W-1:0] beats_in,
    input  logic              active,
    input  logic              ack,
    output logic              any_taken,
    output logic              last_beat
);
    typedef struct packed {
        logic [BEAT_W-1:0] done;
        logic [BEAT_W-1:0] total;
    } beat_t;

    beat_t d, q;

    always_comb begin
        d = q;
        if (load) begin
            d.done  = '0;
            d.total = beats_in;
        end else if (active && ack) begin
            d.done = q.done + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign any_taken = (q.done != '0);
    assign last_beat = active && ack &&
                       (({1'b0, q.done} + 1'b1) >= {1'b0, q.total});
endmodule

// File: rtl/busm_ctrl.sv
module busm_ctrl
    import busm_pkg::*;
#(
    parameter int MIN_LOW     = 2,
    parameter int BEAT_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter bit RETRY_SYNC  = 1'b1
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              ext_req_n,
    input  logic              core_need,
    input  logic              retry_n,
    input  logic              data_ack,
    input  logic              cyc_start,
    input  logic              cyc_write,
    input  logic [BEAT_W-1:0] cyc_beats,
    input  logic              grant_pin_in,
    output logic              grant_n,
    output logic              grant_oe,
    output logic              bus_free,
    output logic              cyc_abort,
    output logic              mode_bit5
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);

    typedef struct packed {
        busm_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic             gnt_n;
        logic             oe;
        logic             abort;
        logic             wr;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, cnt: '0, gnt_n: 1'b1,
                                 oe: 1'b0, abort: 1'b0, wr: 1'b0};

    ctl_t d, q;

    logic req_n_s, req_s;
    logic retry_n_s, retry_s;
    logic any_taken, last_beat;
    logic take_cyc, in_cyc, retry_hit, release_now;
    logic mode_q;

    busm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
        .clk   (clk),
        .rst_n (cold_rst_n),
        .d     (ext_req_n),
        .q     (req_n_s)
    );

    generate
        if (RETRY_SYNC) begin : g_retry_sync
            busm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_retry_sync (
                .clk   (clk),
                .rst_n (cold_rst_n),
                .d     (retry_n),
                .q     (retry_n_s)
            );
        end else begin : g_retry_direct
            assign retry_n_s = retry_n;
        end
    endgenerate

    assign req_s   = ~req_n_s;
    assign retry_s = ~retry_n_s;

    assign take_cyc = (q.st == ST_IDLE) && cyc_start;
    assign in_cyc   = (q.st == ST_CYC);

    busm_beats #(.BEAT_W(BEAT_W)) u_beats (
        .clk       (clk),
        .rst_n     (cold_rst_n),
        .load      (take_cyc),
        .beats_in  (cyc_beats),
        .active    (in_cyc),
        .ack       (data_ack),
        .any_taken (any_taken),
        .last_beat (last_beat)
    );

    // write: retry counts in every beat; read: only before the first beat
    assign retry_hit   = retry_s && (q.wr || !any_taken);
    assign release_now = core_need || !req_s;

    always_comb begin
        d       = q;
        d.abort = 1'b0;
        d.oe    = 1'b1;
        unique case (q.st)
            ST_IDLE: begin
                if (cyc_start) begin
                    d.st = ST_CYC;
                    d.wr = cyc_write;
                end else if (req_s && !core_need) begin
                    d.st    = ST_GMIN;
                    d.cnt   = CNT_W'(MIN_LOW - 1);
                    d.gnt_n = 1'b0;
                end
            end
            ST_CYC: begin
                if (retry_hit) begin
                    d.st    = ST_IDLE;
                    d.abort = 1'b1;
                end else if (last_beat) begin
                    d.st = ST_IDLE;
                end
            end
            ST_GMIN: begin
                if (q.cnt == '0) begin
                    if (release_now) begin
                        d.st    = ST_RECL;
                        d.gnt_n = 1'b1;
                    end else begin
                        d.st = ST_GHOLD;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_GHOLD: begin
                if (release_now) begin
                    d.st    = ST_RECL;
                    d.gnt_n = 1'b1;
                end
            end
            ST_RECL: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st    = ST_IDLE;
                d.gnt_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) q <= CTL_RST;
        else             q <= d;
    end

    // configuration capture: follows the pin only while cold reset is low
    always_ff @(posedge clk) begin
        if (!cold_rst_n) mode_q <= grant_pin_in;
    end

    assign grant_n   = q.gnt_n;
    assign grant_oe  = q.oe;
    assign bus_free  = (q.st == ST_IDLE);
    assign cyc_abort = q.abort;
    assign mode_bit5 = mode_q;
endmodule

// File: rtl/busm_ctrl_chk.sv
module busm_ctrl_chk #(
    parameter int MIN_LOW = 2
) (
    input logic clk,
    input logic cold_rst_n,
    input logic grant_n,
    input logic grant_oe,
    input logic bus_free,
    input logic cyc_abort,
    input logic mode_bit5
);
    logic [7:0] run_q;

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n)          run_q <= '0;
        else if (grant_n)         run_q <= '0;
        else if (run_q != 8'hFF)  run_q <= run_q + 8'd1;
    end

    assert_grant_min_R4: assert property (@(posedge clk) disable iff (!cold_rst_n)
        $rose(grant_n) |-> (32'(run_q) >= MIN_LOW));

    assert_idle_gap_R7: assert property (@(posedge clk) disable iff (!cold_rst_n)
        $rose(grant_n) |-> !bus_free);

    assert_grant_excl_R8: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !grant_n |-> !bus_free);

    assert_abort_pulse_R9: assert property (@(posedge clk) disable iff (!cold_rst_n)
        cyc_abort |=> !cyc_abort);

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!cold_rst_n)
        cyc_abort |-> bus_free);

    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!cold_rst_n)
        $past(cold_rst_n) |-> $stable(mode_bit5));

    assert_pin_input_R13: assert property (@(posedge clk)
        !cold_rst_n |-> !grant_oe);
endmodule

bind busm_ctrl busm_ctrl_chk #(.MIN_LOW(MIN_LOW)) u_chk (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .grant_n    (grant_n),
    .grant_oe   (grant_oe),
    .bus_free   (bus_free),
    .cyc_abort  (cyc_abort),
    .mode_bit5  (mode_bit5)
);

// File: tb/sim_busm_ctrl.sv
module sim_busm_ctrl;
    logic       clk = 1'b0;
    logic       cold_rst_n, ext_req_n, core_need, retry_n, data_ack;
    logic       cyc_start, cyc_write, grant_pin_in;
    logic [2:0] cyc_beats;
    logic       grant_n, grant_oe, bus_free, cyc_abort, mode_bit5;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    busm_ctrl u0 (
        .clk(clk), .cold_rst_n(cold_rst_n), .ext_req_n(ext_req_n),
        .core_need(core_need), .retry_n(retry_n), .data_ack(data_ack),
        .cyc_start(cyc_start), .cyc_write(cyc_write), .cyc_beats(cyc_beats),
        .grant_pin_in(grant_pin_in), .grant_n(grant_n), .grant_oe(grant_oe),
        .bus_free(bus_free), .cyc_abort(cyc_abort), .mode_bit5(mode_bit5)
    );

    // handoff table: release kind (0 core_need, 1 request withdrawn),
    // low sample at which release is applied, expected low clocks
    localparam int NV = 6;
    localparam int V_KIND [NV] = '{0, 0, 0, 1, 1, 0};
    localparam int V_AT   [NV] = '{1, 2, 4, 1, 3, 6};
    localparam int V_EXP  [NV] = '{2, 2, 4, 3, 5, 6};

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic start_cyc(input logic w, input logic [2:0] b);
        cyc_start = 1'b1; cyc_write = w; cyc_beats = b;
        step();
        cyc_start = 1'b0;
        chk("R12 busy after start", int'(bus_free), 0);
    endtask

    task automatic beat();
        data_ack = 1'b1;
        step();
        data_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        cold_rst_n = 1'b0; ext_req_n = 1'b1; core_need = 1'b0; retry_n = 1'b1;
        data_ack = 1'b0; cyc_start = 1'b0; cyc_write = 1'b0; cyc_beats = '0;
        grant_pin_in = 1'b1;

        // reset and configuration capture
        repeat (3) step();
        chk("R13 oe in reset", int'(grant_oe), 0);
        chk("R1 grant in reset", int'(grant_n), 1);
        cold_rst_n = 1'b1;
        step();
        chk("R1 grant", int'(grant_n), 1);
        chk("R1 oe", int'(grant_oe), 1);
        chk("R1 bus_free", int'(bus_free), 1);
        chk("R1 abort", int'(cyc_abort), 0);
        chk("R2 mode captured 1", int'(mode_bit5), 1);
        grant_pin_in = 1'b0;
        repeat (2) step();
        chk("R2 mode kept", int'(mode_bit5), 1);

        // handoff table
        for (int i = 0; i < NV; i++) begin
            int k;
            int idx;
            ext_req_n = 1'b0;
            k = 0;
            do begin
                step();
                k++;
            end while (grant_n && k < 10);
            chk("R3 grant latency", k, 3);
            idx = 1;
            while (grant_n == 1'b0 && idx < 20) begin
                if (idx == V_AT[i]) begin
                    if (V_KIND[i] == 0) core_need = 1'b1;
                    else                ext_req_n = 1'b1;
                end
                step();
                idx++;
            end
            chk(V_KIND[i] == 0 ? "R5 low clocks" : "R6 low clocks", idx - 1, V_EXP[i]);
            chk("R4 minimum low", int'((idx - 1) >= 2), 1);
            chk("R7 idle clock", int'(bus_free), 0);
            step();
            chk("R7 bus back", int'(bus_free), 1);
            ext_req_n = 1'b1;
            repeat (3) step();
            core_need = 1'b0;
            step();
            chk("R6 no regrant", int'(grant_n), 1);
        end

        // plain read completes after exact beat count
        start_cyc(1'b0, 3'd4);
        beat(); beat(); beat();
        chk("R12 still busy", int'(bus_free), 0);
        beat();
        chk("R12 done", int'(bus_free), 1);
        chk("R12 no abort", int'(cyc_abort), 0);
        step();

        // read retry before first beat
        start_cyc(1'b0, 3'd2);
        retry_n = 1'b0;
        step(); chk("R9 abort early", int'(cyc_abort), 0);
        step(); chk("R9 abort early", int'(cyc_abort), 0);
        step();
        chk("R9 abort", int'(cyc_abort), 1);
        chk("R9 bus_free", int'(bus_free), 1);
        retry_n = 1'b1;
        step();
        chk("R9 pulse one clock", int'(cyc_abort), 0);
        repeat (3) step();

        // read retry after first beat ignored
        start_cyc(1'b0, 3'd3);
        beat();
        retry_n = 1'b0;
        for (int j = 0; j < 4; j++) begin
            step();
            chk("R10 no abort", int'(cyc_abort), 0);
            chk("R10 still busy", int'(bus_free), 0);
        end
        retry_n = 1'b1;
        repeat (3) step();
        beat();
        chk("R10 still busy", int'(bus_free), 0);
        beat();
        chk("R10 completes", int'(bus_free), 1);
        chk("R10 no abort", int'(cyc_abort), 0);
        step();

        // write retry after beats
        start_cyc(1'b1, 3'd3);
        beat(); beat();
        retry_n = 1'b0;
        step(); step();
        chk("R11 not yet", int'(cyc_abort), 0);
        step();
        chk("R11 abort", int'(cyc_abort), 1);
        chk("R11 bus_free", int'(bus_free), 1);
        retry_n = 1'b1;
        repeat (3) step();

        // request during a cycle waits for completion
        start_cyc(1'b0, 3'd2);
        ext_req_n = 1'b0;
        for (int j = 0; j < 5; j++) begin
            step();
            chk("R8 held", int'(grant_n), 1);
        end
        beat(); beat();
        chk("R8 held at end", int'(grant_n), 1);
        step();
        chk("R8 granted after cycle", int'(grant_n), 0);
        ext_req_n = 1'b1;
        for (int j = 0; j < 10 && grant_n == 1'b0; j++) step();
        chk("R6 returned", int'(grant_n), 1);
        repeat (3) step();

        // second cold reset with pin low
        cold_rst_n = 1'b0;
        step();
        chk("R13 oe in reset", int'(grant_oe), 0);
        chk("R1 grant in reset", int'(grant_n), 1);
        step();
        cold_rst_n = 1'b1;
        grant_pin_in = 1'b1;
        step();
        chk("R2 mode captured 0", int'(mode_bit5), 0);
        chk("R13 oe after", int'(grant_oe), 1);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule